// File: doc/BRIEF.md
# Host-to-Peripheral Bus Cycle Sequencer

This block turns I/O cycles from a host into timed cycles on a multiplexed peripheral bus. A combinational front end looks at the host's board select, active-low read and write strobes, an active-low 4-bit port number and an active-low init line, and reduces them to a 3-bit command.

A sequencer with a 6-bit state then walks through that command. It makes the peripheral clock itself, at four states per clock period. It drives address strobe, data strobe, chip select, read/write and the interrupt acknowledge line toward the peripherals. Toward the host it drives a transfer acknowledge. It also drives enables for external high-byte and low-byte data latches.

Byte, word and interrupt-acknowledge cycles are supported, as is a repeating init pulse. A fixed recovery period follows every byte-length transfer before the next access may start. All outputs are registered, so each output shows the behaviour of the state the sequencer occupied one clock earlier.

Top module: `pbus_sequencer`

## Requirements
- R1: The command is formed only when `hostBoardSel` is high and `hostRdN` or `hostWrN` is low. A read takes priority when both strobes are active. The port number is the bitwise inverse of `hostPortN`. Port 0 gives interrupt acknowledge (code 5) on a read and no command (0) on a write. Ports 2, 6 and 14 give no command. Port 15 gives word read (3) or word write (4). Every other port gives byte read (1) or byte write (2).
- R2: A low `hostInitN` forces the init command (6) regardless of every other host input.
- R3: `perClk` has a period of four clock cycles (two high, two low) in every sequence without exception. After reset, every active-low output is high, and `perClk` and `perRw` are high.
- R4: While idle, `perAsN` is low for one cycle in each peripheral clock period. `perCsN` goes low with that strobe only if a transfer or interrupt-acknowledge command is present. It stays low for two cycles and never overlaps a low `perDsN`.
- R5: While init is commanded, `perAsN` and `perDsN` are both low on every cycle. After init is released the sequencer returns to idle, with no data strobe.
- R6: `perRw` is low while a byte-write or word-write command is present, and high otherwise.
- R7: A byte read or write holds `perDsN` low for four cycles. `hostAckN` is low for exactly one cycle at the end of every transfer.
- R8: A byte write holds `loLatchEnN` low for six cycles. A word write holds `hiLatchEnN` low for six cycles and then `loLatchEnN` low for four. A word read pulses `hiCaptureEnN` low for one cycle. The two latch enables are never low together.
- R9: A word cycle holds `perDsN` low for six cycles in total. An interrupt-acknowledge cycle holds `perIackN` low for four cycles. After four wait cycles it then holds `perDsN` low for four cycles, never while `perIackN` is low.
- R10: After the acknowledge, the sequencer waits as long as the command stays present. It gives no further acknowledge and no chip select during that time.
- R11: Suppose the command is removed on the cycle the acknowledge is seen and a new command arrives one cycle later. After a byte or interrupt-acknowledge cycle, the next chip select then appears 21 cycles after the acknowledge; this is the five-clock recovery. After a word cycle it appears 5 cycles after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, four per peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostBoardSel | input | 1 | Board selected by host, active high |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostPortN | input | 4 | Host port number, active low |
| hostInitN | input | 1 | Host init request, active low |
| hostAckN | output | 1 | Transfer acknowledge to host, active low |
| perClk | output | 1 | Peripheral bus clock |
| perAsN | output | 1 | Peripheral address strobe, active low |
| perDsN | output | 1 | Peripheral data strobe, active low |
| perCsN | output | 1 | Peripheral chip select, active low |
| perRw | output | 1 | Peripheral read (high) or write (low) |
| perIackN | output | 1 | Interrupt acknowledge to peripherals, active low |
| loLatchEnN | output | 1 | Low data-byte latch load enable, active low |
| hiLatchEnN | output | 1 | High data-byte latch load enable, active low |
| hiCaptureEnN | output | 1 | High-byte capture enable for word reads, active low |

## Verification
The recovery distance after a transfer is the hardest behaviour to pin down from the ports. It depends on the exact cycle, within the post-acknowledge wait loop, at which the command disappears. Dropping it one cycle later shifts the sequencer to a different entry point of the recovery run. The stimulus therefore removes the host strobes on the very sample at which the acknowledge is observed and presents a probe read one cycle later. It then counts cycles until the probe's chip select, which separates the 21-cycle byte recovery from the 5-cycle word return. The waiting loop itself is reached by holding the command for ten cycles past the acknowledge.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_BRD  = 3'd1,
    CMD_BWR  = 3'd2,
    CMD_WRD  = 3'd3,
    CMD_WWR  = 3'd4,
    CMD_IACK = 3'd5,
    CMD_INIT = 3'd6
  } cmd_e;

  localparam int STATE_W = 6;
  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_IDLE0 = 6'd0,  ST_IDLE1 = 6'd1,  ST_IDLE2 = 6'd2,  ST_IDLE3 = 6'd3;
  localparam state_t ST_INIT0 = 6'd4,  ST_INIT1 = 6'd5,  ST_INIT2 = 6'd6,  ST_INIT3 = 6'd7;
  localparam state_t ST_BYTE0 = 6'd8,  ST_BYTE1 = 6'd9,  ST_BYTE2 = 6'd10, ST_BYTE3 = 6'd11;
  localparam state_t ST_BYTE4 = 6'd12, ST_BYTE5 = 6'd13;
  localparam state_t ST_BEND  = 6'd14, ST_BEND0 = 6'd15, ST_BEND1 = 6'd16, ST_BEND2 = 6'd17;
  localparam state_t ST_BEND3 = 6'd18;
  localparam state_t ST_IACK0 = 6'd19, ST_IACK1 = 6'd20, ST_IACK2 = 6'd21, ST_IACK3 = 6'd22;
  localparam state_t ST_WORD0 = 6'd23, ST_WORD1 = 6'd24, ST_WORD2 = 6'd25, ST_WORD3 = 6'd26;
  localparam state_t ST_WEND  = 6'd27, ST_WEND0 = 6'd28, ST_WEND1 = 6'd29, ST_WEND2 = 6'd30;
  localparam state_t ST_WEND3 = 6'd31;
  localparam state_t ST_RECOV = 6'd32;

  // Active-high strobes from control to the pin registers.
  typedef struct packed {
    logic clk;
    logic as;
    logic ds;
    logic cs;
    logic iack;
    logic xack;
    logic loEn;
    logic hiEn;
    logic hiCap;
  } strobe_t;

endpackage

// File: rtl/pbus_cmd_decode.sv
module pbus_cmd_decode
  import pbus_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              boardSel,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [PORT_W-1:0] portN,
  input  logic              initN,
  output cmd_e              cmd
);

  logic [PORT_W-1:0] port;
  logic rd, wr;

  always_comb begin
    port = ~portN;
    rd   = ~rdN;
    wr   = ~wrN;
    cmd  = CMD_NONE;
    if (boardSel && (rd || wr)) begin
      case (port)
        4'd0:              cmd = rd ? CMD_IACK : CMD_NONE;
        4'd2, 4'd6, 4'd14: cmd = CMD_NONE;
        4'd15:             cmd = rd ? CMD_WRD : CMD_WWR;
        default:           cmd = rd ? CMD_BRD : CMD_BWR;
      endcase
    end
    if (!initN) cmd = CMD_INIT;
  end

endmodule

// File: rtl/pbus_seq_ctrl.sv
module pbus_seq_ctrl
  import pbus_pkg::*;
#(
  parameter int RECOV_CLOCKS = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  cmd_e    cmd,
  output strobe_t strb
);

  localparam int     RECOV_STATES = 4 * RECOV_CLOCKS;
  localparam state_t RECOV_LAST   = ST_RECOV + state_t'(RECOV_STATES - 1);

  state_t curState, nextState;
  logic isNone, isIack, isBwr, isWwr, isWrd, isWord;

  always_comb begin
    isNone = (cmd == CMD_NONE);
    isIack = (cmd == CMD_IACK);
    isBwr  = (cmd == CMD_BWR);
    isWwr  = (cmd == CMD_WWR);
    isWrd  = (cmd == CMD_WRD);
    isWord = isWrd || isWwr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE0;
    else       curState <= nextState;
  end

  always_comb begin
    nextState = curState;
    strb      = '0;
    case (curState)
      ST_IDLE0: begin strb.clk = 1'b1; nextState = ST_IDLE1; end
      ST_IDLE1: begin strb.clk = 1'b1; nextState = ST_IDLE2; end
      ST_IDLE2: nextState = ST_IDLE3;
      ST_IDLE3: begin
        strb.as = 1'b1;
        case (cmd)
          CMD_BRD, CMD_BWR, CMD_WRD, CMD_WWR: begin
            strb.cs = 1'b1; nextState = ST_BYTE0;
          end
          CMD_IACK: begin
            strb.cs = 1'b1; strb.iack = 1'b1; nextState = ST_BYTE0;
          end
          CMD_INIT: nextState = ST_INIT0;
          default:  nextState = ST_IDLE0;
        endcase
      end
      ST_INIT0, ST_INIT1, ST_INIT2, ST_INIT3: begin
        strb.clk = ~curState[1];
        strb.as  = 1'b1;
        strb.ds  = 1'b1;
        nextState = curState + 6'd1;
        if (curState == ST_INIT3) nextState = (cmd == CMD_INIT) ? ST_INIT0 : ST_IDLE0;
      end
      ST_BYTE0: begin
        strb.clk = 1'b1; strb.cs = 1'b1; strb.iack = isIack; nextState = ST_BYTE1;
      end
      ST_BYTE1, ST_BYTE2, ST_BYTE3, ST_BYTE4, ST_BYTE5: begin
        strb.clk  = (curState == ST_BYTE1) || (curState == ST_BYTE4) || (curState == ST_BYTE5);
        strb.iack = isIack && (curState == ST_BYTE1 || curState == ST_BYTE2);
        strb.ds   = !isIack && (curState != ST_BYTE1);
        strb.loEn = isBwr;
        strb.hiEn = isWwr;
        nextState = curState + 6'd1;
        if (curState == ST_BYTE5) begin
          strb.hiCap = isWrd;
          nextState  = isWord ? ST_WORD0 : (isIack ? ST_IACK0 : ST_BEND);
        end
      end
      ST_BEND: begin strb.xack = 1'b1; strb.loEn = isBwr; nextState = ST_BEND1; end
      ST_BEND0: nextState = isNone ? ST_RECOV + 6'd1 : ST_BEND1;
      ST_BEND1: begin strb.as = 1'b1; nextState = isNone ? ST_RECOV + 6'd2 : ST_BEND2; end
      ST_BEND2: begin strb.clk = 1'b1; nextState = isNone ? ST_RECOV + 6'd3 : ST_BEND3; end
      ST_BEND3: begin
        strb.clk  = 1'b1;
        nextState = (isNone || cmd == CMD_INIT) ? ST_RECOV : ST_BEND0;
      end
      ST_IACK0, ST_IACK1: nextState = curState + 6'd1;
      ST_IACK2: begin strb.clk = 1'b1; nextState = ST_IACK3; end
      ST_IACK3: begin strb.clk = 1'b1; nextState = ST_WORD0; end
      ST_WORD0: begin strb.ds = isIack; strb.hiEn = isWwr; nextState = ST_WORD1; end
      ST_WORD1: begin strb.ds = isIack; strb.loEn = isWwr; nextState = ST_WORD2; end
      ST_WORD2: begin strb.clk = 1'b1; strb.ds = 1'b1; strb.loEn = isWwr; nextState = ST_WORD3; end
      ST_WORD3: begin
        strb.clk = 1'b1; strb.ds = 1'b1; strb.loEn = isWwr;
        nextState = isIack ? ST_BEND : ST_WEND;
      end
      ST_WEND: begin strb.xack = 1'b1; strb.loEn = isWwr; nextState = ST_WEND1; end
      ST_WEND0: nextState = isNone ? ST_IDLE3 : ST_WEND1;
      ST_WEND1: begin strb.as = 1'b1; nextState = isNone ? ST_IDLE0 : ST_WEND2; end
      ST_WEND2: begin strb.clk = 1'b1; nextState = isNone ? ST_IDLE1 : ST_WEND3; end
      ST_WEND3: begin
        strb.clk  = 1'b1;
        nextState = (isNone || cmd == CMD_INIT) ? ST_IDLE2 : ST_WEND0;
      end
      default: begin
        if (curState >= ST_RECOV && curState <= RECOV_LAST) begin
          strb.clk  = curState[1];
          strb.as   = (curState[1:0] == 2'b01);
          nextState = (curState == RECOV_LAST) ? ST_IDLE2 : curState + 6'd1;
        end else begin
          nextState = ST_IDLE0;
        end
      end
    endcase
  end

endmodule

// File: rtl/pbus_pin_reg.sv
module pbus_pin_reg
  import pbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  cmd_e    cmd,
  output logic    hostAckN,
  output logic    perClk,
  output logic    perAsN,
  output logic    perDsN,
  output logic    perCsN,
  output logic    perRw,
  output logic    perIackN,
  output logic    loLatchEnN,
  output logic    hiLatchEnN,
  output logic    hiCaptureEnN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostAckN     <= 1'b1;
      perClk       <= 1'b1;
      perAsN       <= 1'b1;
      perDsN       <= 1'b1;
      perCsN       <= 1'b1;
      perRw        <= 1'b1;
      perIackN     <= 1'b1;
      loLatchEnN   <= 1'b1;
      hiLatchEnN   <= 1'b1;
      hiCaptureEnN <= 1'b1;
    end else begin
      hostAckN     <= ~strb.xack;
      perClk       <= strb.clk;
      perAsN       <= ~strb.as;
      perDsN       <= ~strb.ds;
      perCsN       <= ~strb.cs;
      perRw        <= !(cmd == CMD_BWR || cmd == CMD_WWR);
      perIackN     <= ~strb.iack;
      loLatchEnN   <= ~strb.loEn;
      hiLatchEnN   <= ~strb.hiEn;
      hiCaptureEnN <= ~strb.hiCap;
    end
  end

endmodule

// File: rtl/pbus_sequencer.sv
module pbus_sequencer
  import pbus_pkg::*;
#(
  parameter int RECOV_CLOCKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostBoardSel,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic [3:0] hostPortN,
  input  logic       hostInitN,
  output logic       hostAckN,
  output logic       perClk,
  output logic       perAsN,
  output logic       perDsN,
  output logic       perCsN,
  output logic       perRw,
  output logic       perIackN,
  output logic       loLatchEnN,
  output logic       hiLatchEnN,
  output logic       hiCaptureEnN
);

  cmd_e    cmd;
  strobe_t strb;

  pbus_cmd_decode #(.PORT_W(4)) u_decode (
    .boardSel (hostBoardSel),
    .rdN      (hostRdN),
    .wrN      (hostWrN),
    .portN    (hostPortN),
    .initN    (hostInitN),
    .cmd      (cmd)
  );

  pbus_seq_ctrl #(.RECOV_CLOCKS(RECOV_CLOCKS)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .strb (strb)
  );

  pbus_pin_reg u_pins (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cmd          (cmd),
    .hostAckN     (hostAckN),
    .perClk       (perClk),
    .perAsN       (perAsN),
    .perDsN       (perDsN),
    .perCsN       (perCsN),
    .perRw        (perRw),
    .perIackN     (perIackN),
    .loLatchEnN   (loLatchEnN),
    .hiLatchEnN   (hiLatchEnN),
    .hiCaptureEnN (hiCaptureEnN)
  );

endmodule

// File: rtl/pbus_sequencer_chk.sv
module pbus_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic hostAckN,
  input logic perClk,
  input logic perDsN,
  input logic perCsN,
  input logic perRw,
  input logic perIackN,
  input logic loLatchEnN,
  input logic hiLatchEnN
);

  logic [2:0] warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= 3'd0;
    else if (warmCnt != 3'd7) warmCnt <= warmCnt + 3'd1;
  end

  // R3
  clk_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 3'd5) |-> (perClk != $past(perClk, 2)));

  // R4
  cs_ds_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !perCsN |-> perDsN);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostAckN |=> hostAckN);

  // R9
  iack_no_ds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !perIackN |-> perDsN);

  // R8
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!loLatchEnN && !hiLatchEnN));

  // R6
  latch_write_rw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loLatchEnN || !hiLatchEnN) |-> !perRw);

endmodule

bind pbus_sequencer pbus_sequencer_chk u_chk (.*);

// File: tb/pbus_sequencer_tb.sv
module pbus_sequencer_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, rdN = 1'b1, wrN = 1'b1, initN = 1'b1;
  logic [3:0] portN = 4'hF;
  logic hostAckN, perClk, perAsN, perDsN, perCsN, perRw, perIackN;
  logic loLatchEnN, hiLatchEnN, hiCaptureEnN;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int nDs, nCs, nLo, nHi, nCap, nIack, nAck, nRwLowCs, nRwLow, recover, holdCs, holdAck;

  always #5 clk = ~clk;

  pbus_sequencer u_dut (
    .clk(clk), .rstN(rstN), .hostBoardSel(sel), .hostRdN(rdN), .hostWrN(wrN),
    .hostPortN(portN), .hostInitN(initN), .hostAckN(hostAckN), .perClk(perClk),
    .perAsN(perAsN), .perDsN(perDsN), .perCsN(perCsN), .perRw(perRw),
    .perIackN(perIackN), .loLatchEnN(loLatchEnN), .hiLatchEnN(hiLatchEnN),
    .hiCaptureEnN(hiCaptureEnN)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic dropHost();
    sel = 1'b0; rdN = 1'b1; wrN = 1'b1; portN = 4'hF;
  endtask

  task automatic driveHost(input bit rd, input logic [3:0] port);
    sel = 1'b1; rdN = !rd; wrN = rd; portN = ~port;
  endtask

  // Runs one transfer; drops the strobes at the acknowledge (after an optional hold),
  // then measures the distance to the chip select of a probe byte read.
  task automatic xfer(input bit rd, input logic [3:0] port, input int hold);
    nDs = 0; nCs = 0; nLo = 0; nHi = 0; nCap = 0; nIack = 0; nAck = 0;
    nRwLowCs = 0; nRwLow = 0; recover = 0; holdCs = 0; holdAck = 0;
    @(negedge clk);
    driveHost(rd, port);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      nDs  += int'(!perDsN);
      nCs  += int'(!perCsN);
      nLo  += int'(!loLatchEnN);
      nHi  += int'(!hiLatchEnN);
      nCap += int'(!hiCaptureEnN);
      nIack += int'(!perIackN);
      nRwLow += int'(!perRw);
      nRwLowCs += int'(!perRw && !perCsN);
      if (!hostAckN) begin nAck++; break; end
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      holdCs  += int'(!perCsN);
      holdAck += int'(!hostAckN);
    end
    dropHost();
    if (hold == 0) begin
      @(negedge clk);
      recover = 1;
      driveHost(1'b1, 4'd1);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        recover++;
        if (!perCsN) break;
      end
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!hostAckN) break;
      end
      dropHost();
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic noCmdCase(input string tag, input logic s, input logic r, input logic w,
                           input logic [3:0] port);
    int cs = 0, ia = 0;
    @(negedge clk);
    sel = s; rdN = r; wrN = w; portN = ~port;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cs += int'(!perCsN);
      ia += int'(!perIackN);
    end
    chkEq("R1", {tag, " chip select cycles"}, cs, 0);
    chkEq("R1", {tag, " iack cycles"}, ia, 0);
    dropHost();
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    chkEq("R3", "reset ack", int'(hostAckN), 1);
    chkEq("R3", "reset as/ds/cs", int'({perAsN, perDsN, perCsN}), 7);
    chkEq("R3", "reset iack/latches", int'({perIackN, loLatchEnN, hiLatchEnN, hiCaptureEnN}), 15);
    chkEq("R3", "reset clk/rw", int'({perClk, perRw}), 3);
  endtask

  task automatic testIdle();
    logic [15:0] c;
    int asLow = 0, csLow = 0, bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      c[i] = perClk;
      asLow += int'(!perAsN);
      csLow += int'(!perCsN);
      if (i >= 2 && c[i] == c[i-2]) bad++;
      if (!perAsN && perClk) bad++;
    end
    chkEq("R3", "idle clock pattern errors", bad, 0);
    chkEq("R4", "idle address strobes in 16", asLow, 4);
    chkEq("R4", "idle chip selects", csLow, 0);
  endtask

  task automatic testInit(input bit withRead);
    int both = 0, cs = 0, ds = 0, as = 0;
    @(negedge clk);
    initN = 1'b0;
    if (withRead) driveHost(1'b1, 4'd1);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      both += int'(!perAsN && !perDsN);
      cs   += int'(!perCsN);
    end
    chkEq(withRead ? "R2" : "R5", "init both strobes low", both, 12);
    chkEq(withRead ? "R2" : "R5", "init chip selects", cs, 0);
    initN = 1'b1;
    dropHost();
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ds += int'(!perDsN);
      as += int'(!perAsN);
    end
    chkEq("R5", "post-init data strobes", ds, 0);
    chkEq("R5", "post-init address strobes", as, 3);
  endtask

  task automatic testByteRead();
    xfer(1'b1, 4'd1, 0);
    chkEq("R4", "byte read chip select cycles", nCs, 2);
    chkEq("R7", "byte read data strobe cycles", nDs, 4);
    chkEq("R7", "byte read acks", nAck, 1);
    chkEq("R6", "byte read rw low cycles", nRwLow, 0);
    chkEq("R8", "byte read latch enables", nLo + nHi + nCap, 0);
    chkEq("R11", "byte recovery distance", recover, 21);
  endtask

  task automatic testByteWrite();
    xfer(1'b0, 4'd9, 0);
    chkEq("R8", "byte write low latch cycles", nLo, 6);
    chkEq("R8", "byte write high latch cycles", nHi, 0);
    chkEq("R6", "byte write rw low with cs", nRwLowCs, 2);
    chkEq("R7", "byte write data strobe cycles", nDs, 4);
    chkEq("R11", "byte write recovery distance", recover, 21);
  endtask

  task automatic testWordRead();
    xfer(1'b1, 4'd15, 0);
    chkEq("R9", "word read data strobe cycles", nDs, 6);
    chkEq("R8", "word read capture cycles", nCap, 1);
    chkEq("R7", "word read acks", nAck, 1);
    chkEq("R11", "word return distance", recover, 5);
  endtask

  task automatic testWordWrite();
    xfer(1'b0, 4'd15, 0);
    chkEq("R8", "word write high latch cycles", nHi, 6);
    chkEq("R8", "word write low latch cycles", nLo, 4);
    chkEq("R6", "word write rw low with cs", nRwLowCs, 2);
    chkEq("R9", "word write data strobe cycles", nDs, 6);
  endtask

  task automatic testIack();
    xfer(1'b1, 4'd0, 0);
    chkEq("R1", "iack chip select cycles", nCs, 2);
    chkEq("R9", "iack line cycles", nIack, 4);
    chkEq("R9", "iack data strobe cycles", nDs, 4);
    chkEq("R11", "iack recovery distance", recover, 21);
  endtask

  task automatic testHold();
    xfer(1'b1, 4'd3, 10);
    chkEq("R10", "hold chip selects", holdCs, 0);
    chkEq("R10", "hold extra acks", holdAck, 0);
    xfer(1'b1, 4'd5, 0);
    chkEq("R10", "transfer after hold acks", nAck, 1);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testIdle();
    testByteRead();
    testByteWrite();
    testWordRead();
    testWordWrite();
    testIack();
    testHold();
    noCmdCase("write port 0", 1'b1, 1'b1, 1'b0, 4'd0);
    noCmdCase("spare port 2", 1'b1, 1'b0, 1'b1, 4'd2);
    noCmdCase("spare port 6", 1'b1, 1'b0, 1'b1, 4'd6);
    noCmdCase("spare port 14", 1'b1, 1'b1, 1'b0, 4'd14);
    noCmdCase("not selected", 1'b0, 1'b0, 1'b1, 4'd1);
    testInit(1'b0);
    testInit(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule